// File: doc/BRIEF.md
# Circular Wear-Leveling Slot Controller

This block spreads repeated writes of a single byte-wide setting over a ring of slots, so that no one storage cell takes every update. It keeps two equal-sized rings: one holds the data bytes and the other holds one sequence byte per slot. The controller never holds the position of the next slot in a register of its own. On every request it walks the sequence ring from slot 0 and takes the first slot whose sequence byte is not one more, modulo 256, than the byte of the slot before it. The walk wraps, so slot 0 is compared with the last slot.

A write request puts the data byte into the slot the walk found. The same step sets that slot's sequence byte to the previous slot's byte plus one. A read request returns the byte held in the slot just before the found slot, which is the value written most recently. A requester sees a valid/ready handshake with a write-enable bit. A busy flag stays high while the walk runs, and the read data output holds the result of the last request that finished.

Top module: `wl_ring_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `req_ready` is 1, `rd_data` is 0x00, and every data and sequence byte is 0x00.
- R2: `req_ready` is 1 exactly when the block is not busy. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both 1, and `busy` is 1 from the next cycle on.
- R3: The target slot H is the lowest index i, counting from 0, where seq[(i-1) mod N] + 1 (modulo 256) differs from seq[i]. `busy` stays high for exactly H+1 cycles after the request is taken.
- R4: A write (`req_we`=1) stores `req_wdata` in data slot H and sets seq[H] to seq[(H-1) mod N] + 1 modulo 256. When the request completes, `rd_data` equals the byte that was written.
- R5: A read (`req_we`=0) leaves both rings unchanged. On completion it sets `rd_data` to data slot (H-1) mod N, which is the last slot when H is 0, and 0x00 straight after reset. While the block is idle, `rd_data` holds its value.
- R6: While `busy` is 1, `req_valid`, `req_we` and `req_wdata` have no effect.
- R7: Sequence arithmetic is 8-bit. Once sequence bytes have wrapped from 255 to 0 any number of times, slot selection and read-back still follow R3 to R5.
- R8: The slot count parameter must be between 2 and 255. Any other value stops elaboration with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Byte to store on a write |
| rd_data | output | 8 | Byte from the last completed request |
| busy | output | 1 | Slot search in progress |

## Verification
The case that is hardest to reach is a sequence ring whose bytes have wrapped past 255. From the ports, this needs several hundred writes, and each write moves the ring by only one step. The stimulus runs a long random mix of reads and writes, then a long run of back-to-back writes, so that the sequence bytes pass zero several times with the target slot at every position. Every request is compared with a bench model of both rings, which also predicts the busy length that shows where the target slot is. Some requests also raise a second request while the block is busy, to show that it is ignored.

// File: rtl/wl_ring_pkg.sv
package wl_ring_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } wl_state_e;

    function automatic byte_t seq_inc(input byte_t v);
        return v + 8'd1;
    endfunction

endpackage

// File: rtl/wl_ring_store.sv
module wl_ring_store
    import wl_ring_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int IW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] cur_idx,
    input  logic [IW-1:0] prev_idx,
    output byte_t         seq_cur,
    output byte_t         seq_prev,
    output byte_t         data_prev,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  byte_t         wr_data,
    input  byte_t         wr_seq
);

    byte_t data_q [SLOTS];
    byte_t seq_q  [SLOTS];

    assign seq_cur   = seq_q[cur_idx];
    assign seq_prev  = seq_q[prev_idx];
    assign data_prev = data_q[prev_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < SLOTS; k++) begin
                data_q[k] <= '0;
                seq_q[k]  <= '0;
            end
        end else if (wr_en) begin
            data_q[wr_idx] <= wr_data;
            seq_q[wr_idx]  <= wr_seq;
        end
    end

endmodule

// File: rtl/wl_seq_break.sv
module wl_seq_break
    import wl_ring_pkg::*;
(
    input  byte_t seq_prev,
    input  byte_t seq_cur,
    output logic  brk
);

    assign brk = (seq_inc(seq_prev) != seq_cur);

endmodule

// File: rtl/wl_ring_ctrl.sv
module wl_ring_ctrl
    import wl_ring_pkg::*;
#(
    parameter int SLOTS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_we,
    input  logic [7:0] req_wdata,
    output logic [7:0] rd_data,
    output logic       busy
);

    localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [IW-1:0] LAST = IW'(SLOTS - 1);

    // R8: the +1 chain only has a guaranteed break below 256 slots
    generate
        if (SLOTS < 2 || SLOTS > 255) begin : g_bad_slots
            $error("wl_ring_ctrl: SLOTS must be in 2..255");
        end
    endgenerate

    typedef struct packed {
        wl_state_e     state;
        logic [IW-1:0] idx;
        logic          we_pend;
        byte_t         wdata;
        byte_t         rdata;
    } ctrl_t;

    ctrl_t q, d;

    logic [IW-1:0] prev_idx;
    byte_t         seq_cur, seq_prev, data_prev;
    logic          brk;
    logic          mem_we;

    assign prev_idx = (q.idx == '0) ? LAST : q.idx - 1'b1;

    wl_ring_store #(.SLOTS(SLOTS), .IW(IW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_idx   (q.idx),
        .prev_idx  (prev_idx),
        .seq_cur   (seq_cur),
        .seq_prev  (seq_prev),
        .data_prev (data_prev),
        .wr_en     (mem_we),
        .wr_idx    (q.idx),
        .wr_data   (q.wdata),
        .wr_seq    (seq_inc(seq_prev))
    );

    wl_seq_break u_brk (
        .seq_prev (seq_prev),
        .seq_cur  (seq_cur),
        .brk      (brk)
    );

    always_comb begin
        d      = q;
        mem_we = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.state   = ST_SCAN;
                    d.idx     = '0;
                    d.we_pend = req_we;
                    d.wdata   = req_wdata;
                end
            end
            ST_SCAN: begin
                if (brk) begin
                    d.state = ST_IDLE;
                    if (q.we_pend) begin
                        mem_we  = 1'b1;
                        d.rdata = q.wdata;
                    end else begin
                        d.rdata = data_prev;
                    end
                end else begin
                    d.idx = (q.idx == LAST) ? '0 : q.idx + 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, idx: '0, we_pend: 1'b0, wdata: '0, rdata: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.state == ST_IDLE);
    assign busy      = (q.state == ST_SCAN);
    assign rd_data   = q.rdata;

endmodule

// File: rtl/wl_ring_ctrl_chk.sv
module wl_ring_ctrl_chk #(
    parameter int SLOTS = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       busy,
    input logic [7:0] rd_data,
    input logic       pend_we,
    input logic [7:0] pend_wdata
);

    logic [8:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     busy_cnt <= '0;
        else if (busy)  busy_cnt <= busy_cnt + 1'b1;
        else            busy_cnt <= '0;
    end

    p_take_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

    p_ready_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    p_scan_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < 9'(SLOTS)));

    p_write_echo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && pend_we) |-> (rd_data == pend_wdata));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(rd_data));

    p_ignore_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(pend_wdata) && $stable(pend_we)));

endmodule

bind wl_ring_ctrl wl_ring_ctrl_chk #(.SLOTS(SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .busy       (busy),
    .rd_data    (rd_data),
    .pend_we    (q.we_pend),
    .pend_wdata (q.wdata)
);

// File: tb/test_wl_ring_ctrl.sv
`timescale 1ns/1ps
module test_wl_ring_ctrl;

    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_we = 1'b0;
    logic [7:0] req_wdata = '0;
    logic [7:0] rd_data;
    logic       busy;

    int checks = 0;
    int errors = 0;
    int wraps  = 0;
    bit done   = 1'b0;

    logic [7:0] m_data [N];
    logic [7:0] m_seq  [N];

    always #5 clk = ~clk;

    wl_ring_ctrl #(.SLOTS(N)) i_wl_ring_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_we    (req_we),
        .req_wdata (req_wdata),
        .rd_data   (rd_data),
        .busy      (busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int find_head();
        for (int i = 0; i < N; i++) begin
            if (8'(m_seq[(i + N - 1) % N] + 8'd1) != m_seq[i]) return i;
        end
        return -1;
    endfunction

    task automatic do_req(input bit we, input logic [7:0] wd, input bit poke);
        int h, cnt;
        logic [7:0] exp_rd;
        h = find_head();
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready when idle", int'(req_ready), 1);
        req_valid = 1'b1;
        req_we    = we;
        req_wdata = wd;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (cnt == 0 && poke) begin
                req_valid = 1'b1;
                req_we    = ~we;
                req_wdata = ~wd;
            end else begin
                req_valid = 1'b0;
            end
            if (!busy) break;
            cnt++;
        end
        req_valid = 1'b0;
        chk(cnt == h + 1, "R3 busy length", cnt, h + 1);
        if (we) begin
            m_data[h] = wd;
            m_seq[h]  = 8'(m_seq[(h + N - 1) % N] + 8'd1);
            if (m_seq[h] == 8'd0) wraps++;
            exp_rd = wd;
            chk(rd_data == exp_rd, "R4 write echo", int'(rd_data), int'(exp_rd));
        end else begin
            exp_rd = m_data[(h + N - 1) % N];
            chk(rd_data == exp_rd, "R5 read last slot", int'(rd_data), int'(exp_rd));
        end
        if (poke) begin
            @(negedge clk);
            chk(busy == 1'b0 && rd_data == exp_rd, "R6 busy request ignored",
                int'(rd_data), int'(exp_rd));
        end
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1357));
        for (int k = 0; k < N; k++) begin
            m_data[k] = '0;
            m_seq[k]  = '0;
        end
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(rd_data == 8'd0, "R1 rd_data after reset", int'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: read straight after reset gives 0 from the last slot, head 0
        do_req(1'b0, 8'h00, 1'b0);
        // R4: first writes fill slots in order
        do_req(1'b1, 8'h07, 1'b0);
        do_req(1'b1, 8'h04, 1'b0);
        do_req(1'b0, 8'h00, 1'b0);
        // R6: requests raised while busy
        do_req(1'b1, 8'h09, 1'b1);
        do_req(1'b0, 8'h00, 1'b1);

        // R5: rd_data holds while idle
        repeat (4) @(negedge clk);
        chk(rd_data == m_data[(find_head() + N - 1) % N], "R5 idle hold",
            int'(rd_data), int'(m_data[(find_head() + N - 1) % N]));

        for (int k = 0; k < 400; k++) begin
            bit we;
            we = ($urandom % 10) < 6;
            do_req(we, 8'($urandom), ($urandom % 8) == 0);
        end
        for (int k = 0; k < 700; k++) begin
            do_req(1'b1, 8'($urandom), 1'b0);
            if (k % 50 == 0) do_req(1'b0, 8'h00, 1'b0);
        end
        // R7: sequence bytes crossed 255 several times with correct results
        chk(wraps >= 3, "R7 sequence wraps covered", wraps, 3);
        do_req(1'b0, 8'h00, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule